// File: doc/BRIEF.md
# Sleep-Mode Wake Qualifier

This block watches a transceiver's two wake sources while the device sleeps and decides when a genuine wake request has arrived. The first source is the bus receiver's level, already synchronised, reported as dominant or recessive. The second is an active-low local wake pin, also synchronised. A glitch, or a level that was already asserted before sleep began, must not wake the device. A held request must.

The two sources are qualified in different ways. The local pin needs a fresh falling edge, and the pin must then stay low for longer than its filter count. It is reported as soon as that count is exceeded. The bus also needs a fresh edge into dominant and a dominant period longer than its own filter count. The bus wake is reported only when the bus returns to recessive. The result is a one-cycle wake pulse with a source tag, which the mode controller uses to move from sleep to stand-by. Both filter counts are clock-count parameters, sized so that they cover a 30 to 150 µs window at the system clock.

Top module: `wake_qualifier`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `wake_o` is 0 and `wake_src_o` is 0.
- R2: In sleep, once the local pin is armed, a low level on `wake_pin_n_i` sampled on LOC_FILT_CYC+1 consecutive clock edges produces a wake pulse. The pulse is registered on that last edge and tagged `wake_src_o` = 1. A low level lasting exactly LOC_FILT_CYC edges produces no pulse.
- R3: In sleep, once the bus is armed, `bus_dom_i` = 1 (dominant) sampled on more than BUS_FILT_CYC consecutive edges qualifies a bus wake. No pulse appears while the bus stays dominant. The pulse is registered on the first edge that samples `bus_dom_i` = 0, and it is tagged `wake_src_o` = 0.
- R4: A dominant period of BUS_FILT_CYC edges or fewer produces no bus wake.
- R5: Each wake pulse lasts exactly one cycle. `wake_src_o` is 0 whenever `wake_o` is 0. Its encoding is 1 for local and 0 for bus.
- R6: A low (or dominant) interval that ends before it qualifies clears that source's timer. The next falling edge starts a new count from zero.
- R7: If a source is already low or dominant when sleep starts, or when sleep drops and returns mid-count, that source produces no wake until it has gone inactive and then shown a fresh falling edge.
- R8: While `sleep_i` is 0, no wake pulse is produced and both timers are held cleared.
- R9: If both sources qualify on the same edge, a single pulse is produced, tagged local (`wake_src_o` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | 1 while the device is in sleep; enables detection |
| bus_dom_i | input | 1 | Synchronised bus level, 1 = dominant |
| wake_pin_n_i | input | 1 | Synchronised local wake pin, active low |
| wake_o | output | 1 | One-cycle qualified wake pulse |
| wake_src_o | output | 1 | Source of the pulse: 1 = local, 0 = bus |

## Verification
The bench places low intervals exactly at each filter count and one edge beyond it. A detector that used "at least" instead of "longer than" would fire on the boundary case, and one that was off by one the other way would miss the first qualifying length. Bus wakes are checked for silence through a long dominant hold and for a pulse on the release edge only, which catches a design that reports when the timer expires.

Levels that are already asserted at sleep entry, or after a sleep drop mid-count, expose a detector that is level-triggered rather than edge-armed. A short pulse followed by a new edge exposes a timer that is not cleared. A coincident local qualification and bus release shows whether the source priority is right and whether two pulses are emitted instead of one.

// File: rtl/wkq_pkg.sv
package wkq_pkg;

  typedef enum logic [1:0] {
    CH_WAIT_IDLE = 2'd0,
    CH_ARMED     = 2'd1,
    CH_TIMING    = 2'd2,
    CH_HELD      = 2'd3
  } ch_state_e;

  localparam logic SRC_BUS   = 1'b0;
  localparam logic SRC_LOCAL = 1'b1;

  localparam int NUM_SRC = 2;
  localparam int IDX_BUS = 0;
  localparam int IDX_LOC = 1;

  // Local wins whenever it fires; otherwise the pulse belongs to the bus.
  function automatic logic pick_src(input logic loc_fired);
    return loc_fired ? SRC_LOCAL : SRC_BUS;
  endfunction

endpackage

// File: rtl/wkq_channel.sv
module wkq_channel
  import wkq_pkg::*;
#(
  parameter int FILT_CYC     = 40,
  parameter bit NEED_RELEASE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic active_i,
  output logic fire_o
);

  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC);

  ch_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic fire_c;

  // Saturating increment of the active-sample count.
  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return (c == LIMIT) ? c : c + CW'(1);
  endfunction

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    fire_c = 1'b0;
    if (!en_i) begin
      st_d  = CH_WAIT_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        CH_WAIT_IDLE: if (!active_i) st_d = CH_ARMED;
        CH_ARMED: if (active_i) begin
          st_d  = CH_TIMING;
          cnt_d = CW'(1);
        end
        CH_TIMING: begin
          if (!active_i) begin
            st_d  = CH_ARMED;
            cnt_d = '0;
          end else if (cnt_q == LIMIT) begin
            cnt_d = '0;
            if (NEED_RELEASE) begin
              st_d = CH_HELD;
            end else begin
              fire_c = 1'b1;
              st_d   = CH_WAIT_IDLE;
            end
          end else begin
            cnt_d = bump(cnt_q);
          end
        end
        CH_HELD: if (!active_i) begin
          fire_c = 1'b1;
          st_d   = CH_ARMED;
        end
        default: st_d = CH_WAIT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CH_WAIT_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign fire_o = fire_c;

endmodule

// File: rtl/wake_qualifier.sv
module wake_qualifier
  import wkq_pkg::*;
#(
  parameter int BUS_FILT_CYC = 40,
  parameter int LOC_FILT_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic bus_dom_i,
  input  logic wake_pin_n_i,
  output logic wake_o,
  output logic wake_src_o
);

  logic [NUM_SRC-1:0] active_vec;
  logic [NUM_SRC-1:0] fire_vec;
  logic bus_fire;
  logic loc_fire;
  logic any_fire;

  assign active_vec[IDX_BUS] = bus_dom_i;
  assign active_vec[IDX_LOC] = ~wake_pin_n_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int FILT = (g == IDX_BUS) ? BUS_FILT_CYC : LOC_FILT_CYC;
    localparam bit REL  = (g == IDX_BUS);
    wkq_channel #(
      .FILT_CYC    (FILT),
      .NEED_RELEASE(REL)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (sleep_i),
      .active_i(active_vec[g]),
      .fire_o  (fire_vec[g])
    );
  end

  assign bus_fire = fire_vec[IDX_BUS];
  assign loc_fire = fire_vec[IDX_LOC];
  assign any_fire = bus_fire | loc_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_o     <= 1'b0;
      wake_src_o <= SRC_BUS;
    end else begin
      wake_o     <= any_fire;
      wake_src_o <= any_fire ? pick_src(loc_fire) : SRC_BUS;
    end
  end

endmodule

// File: rtl/wake_qualifier_chk.sv
module wake_qualifier_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_i,
  input logic bus_dom_i,
  input logic wake_pin_n_i,
  input logic wake_o,
  input logic wake_src_o,
  input logic bus_fire,
  input logic loc_fire
);

  AST_NOFIRE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |-> !(bus_fire || loc_fire));                                   // R8
  AST_PULSE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(sleep_i));                                              // R8
  AST_BUS_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fire |-> (!bus_dom_i && $past(bus_dom_i)));                          // R3
  AST_LOCAL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    loc_fire |-> (!wake_pin_n_i && $past(!wake_pin_n_i)));                   // R2
  AST_BUS_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fire |=> !bus_fire);                                                 // R5
  AST_LOC_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    loc_fire |=> !loc_fire);                                                 // R5
  AST_SRC_ONLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_src_o |-> wake_o);                                                  // R5
  AST_BOTH_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_fire && loc_fire) |=> (wake_o && wake_src_o));                      // R9

endmodule

bind wake_qualifier wake_qualifier_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_i     (sleep_i),
  .bus_dom_i   (bus_dom_i),
  .wake_pin_n_i(wake_pin_n_i),
  .wake_o      (wake_o),
  .wake_src_o  (wake_src_o),
  .bus_fire    (bus_fire),
  .loc_fire    (loc_fire)
);

// File: tb/sim_wake_qualifier.sv
module sim_wake_qualifier;

  localparam int CLK_P = 10;
  localparam int BF    = 12;
  localparam int LF    = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_i = 1'b0;
  logic bus_dom_i = 1'b0;
  logic wake_pin_n_i = 1'b1;
  logic wake_o;
  logic wake_src_o;

  int n_run = 0;
  int n_fail = 0;
  int n_pulse = 0;
  int last_src = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wake_qualifier #(.BUS_FILT_CYC(BF), .LOC_FILT_CYC(LF)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .bus_dom_i(bus_dom_i),
    .wake_pin_n_i(wake_pin_n_i), .wake_o(wake_o), .wake_src_o(wake_src_o)
  );

  // Vector: [9] source (0 bus, 1 local), [8:1] active edges, [0] wake expected
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 8'(BF),      1'b0},
    {1'b0, 8'(BF + 1),  1'b1},
    {1'b0, 8'(BF + 20), 1'b1},
    {1'b0, 8'(3),       1'b0},
    {1'b1, 8'(LF),      1'b0},
    {1'b1, 8'(LF + 1),  1'b1},
    {1'b1, 8'(LF + 15), 1'b1},
    {1'b1, 8'(1),       1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (wake_o) begin
        n_pulse++;
        last_src = int'(wake_src_o);
      end
    end
  endtask

  task automatic rearm();
    sleep_i = 1'b0;
    bus_dom_i = 1'b0;
    wake_pin_n_i = 1'b1;
    tick(2);
    sleep_i = 1'b1;
    tick(2);
    n_pulse = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 reset wake", int'(wake_o), 0);
    check("R1 reset src", int'(wake_src_o), 0);
    tick(2);
    rst_n = 1'b1;
    tick(1);
    check("R1 after reset wake", int'(wake_o), 0);

    // Table walk: R2 R3 R4
    for (int v = 0; v < 8; v++) begin
      rearm();
      if (VEC[v][9]) wake_pin_n_i = 1'b0; else bus_dom_i = 1'b1;
      tick(int'(VEC[v][8:1]));
      wake_pin_n_i = 1'b1;
      bus_dom_i = 1'b0;
      tick(4);
      check(VEC[v][9] ? "R2 local vector pulses" : "R3 R4 bus vector pulses",
            n_pulse, int'(VEC[v][0]));
      if (VEC[v][0]) check("R5 vector source tag", last_src, int'(VEC[v][9]));
    end

    // R2 exact edge of local pulse, R5 one cycle
    rearm();
    wake_pin_n_i = 1'b0;
    tick(LF);
    check("R2 no pulse at filter count", int'(wake_o), 0);
    tick(1);
    check("R2 pulse one edge later", int'(wake_o), 1);
    check("R5 local tag", int'(wake_src_o), 1);
    tick(1);
    check("R5 pulse width one", int'(wake_o), 0);
    check("R5 src cleared", int'(wake_src_o), 0);
    wake_pin_n_i = 1'b1;
    tick(3);

    // R3 bus silent while dominant, fires on release
    rearm();
    bus_dom_i = 1'b1;
    tick(BF + 10);
    check("R3 silent while dominant", n_pulse, 0);
    bus_dom_i = 1'b0;
    tick(1);
    check("R3 pulse on release", int'(wake_o), 1);
    check("R3 bus tag", int'(wake_src_o), 0);
    tick(1);
    check("R5 bus pulse width one", int'(wake_o), 0);

    // R8 nothing while awake
    rearm();
    sleep_i = 1'b0;
    wake_pin_n_i = 1'b0;
    bus_dom_i = 1'b1;
    tick(30);
    bus_dom_i = 1'b0;
    wake_pin_n_i = 1'b1;
    tick(4);
    check("R8 no wake outside sleep", n_pulse, 0);

    // R7 level already low at sleep entry
    sleep_i = 1'b0;
    wake_pin_n_i = 1'b0;
    bus_dom_i = 1'b1;
    tick(2);
    sleep_i = 1'b1;
    n_pulse = 0;
    tick(30);
    bus_dom_i = 1'b0;
    tick(3);
    check("R7 pre-asserted levels ignored", n_pulse, 0);
    wake_pin_n_i = 1'b1;
    tick(2);
    wake_pin_n_i = 1'b0;
    tick(LF + 1);
    check("R7 fresh edge qualifies", n_pulse, 1);
    wake_pin_n_i = 1'b1;
    tick(2);

    // R7 sleep drop mid-count
    rearm();
    wake_pin_n_i = 1'b0;
    tick(5);
    sleep_i = 1'b0;
    tick(1);
    sleep_i = 1'b1;
    tick(LF + 5);
    check("R7 sleep drop needs new edge", n_pulse, 0);
    wake_pin_n_i = 1'b1;
    tick(2);

    // R6 short pulse clears timer
    rearm();
    wake_pin_n_i = 1'b0;
    tick(LF - 2);
    wake_pin_n_i = 1'b1;
    tick(1);
    wake_pin_n_i = 1'b0;
    tick(LF);
    check("R6 timer restarted from zero", n_pulse, 0);
    tick(1);
    check("R6 full count after new edge", n_pulse, 1);
    wake_pin_n_i = 1'b1;
    rearm();
    bus_dom_i = 1'b1;
    tick(BF - 1);
    bus_dom_i = 1'b0;
    tick(1);
    bus_dom_i = 1'b1;
    tick(BF);
    bus_dom_i = 1'b0;
    tick(3);
    check("R6 bus short then short", n_pulse, 0);

    // R9 both on the same edge
    rearm();
    bus_dom_i = 1'b1;
    tick(BF + 3);
    wake_pin_n_i = 1'b0;
    tick(LF);
    bus_dom_i = 1'b0;
    tick(1);
    check("R9 coincident pulse", int'(wake_o), 1);
    check("R9 local priority", int'(wake_src_o), 1);
    wake_pin_n_i = 1'b1;
    tick(4);
    check("R9 single pulse", n_pulse, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule